// File: doc/BRIEF.md
# AES-128 Decryption Key Pre-Generator

This block turns a 128-bit AES cipher key into the last round key of the standard AES-128 key schedule. A later inverse-cipher pass starts from that key, so the expansion does not have to be repeated for every decryption. Software loads the key one byte per write. In the key-generation mode, the schedule starts on its own as soon as the sixteenth byte arrives. While the block works a busy flag is raised. When the work is complete a ready flag comes up, and the result is read back one byte per read.

The block keeps a 2-bit operation mode and four status flags: busy, ready, key-written and output-read. Writing the mode restarts key loading. In the decrypt-with-pregenerated-key mode, software may mark the key as valid directly instead of loading it again.

Top module: `aes_dkey_pregen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy, ready, key_written and out_read_done are 0 and mode reads 2'b00.
- R2: A write to the mode field clears key_written in the next cycle and restarts key byte counting, so the following key write is again taken as byte 0.
- R3: The key is taken as 16 byte writes, the first write being byte 0 (most significant byte of the 128-bit key). key_written stays 0 until the 16th byte is accepted and is 1 in the cycle after it.
- R4: In mode 2'b10 (decryption key generation), accepting the 16th key byte starts generation with no other command. busy is 1 from the next cycle for exactly 53 cycles.
- R5: When busy falls, ready is 1. The output port then yields the tenth round key of the AES-128 schedule, byte 0 first. That schedule uses RotWord then SubWord on the last word of each round and round constants 01,02,04,08,10,20,40,80,1B,36.
- R6: out_read_done is 0 when generation starts, stays 0 through the first 15 output reads, and is 1 after the 16th read.
- R7: While busy is 0, a read of the output port, a key-port write or a data-input-port write clears ready in the next cycle.
- R8: In mode 2'b11 (decrypt with pregenerated key), pulsing key_valid_set sets key_written without a key load. In any other mode the pulse leaves key_written unchanged.
- R9: Key-port writes while busy is 1 are ignored: they change neither the result nor key_written.
- R10: Loading all 16 key bytes in a mode other than 2'b10 sets key_written but does not start generation (busy stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the operation mode field |
| mode_wdata | input | 2 | New mode value (2'b10 generate, 2'b11 decrypt with pregenerated key) |
| mode | output | 2 | Current mode field |
| key_wr | input | 1 | Key port byte write strobe |
| key_wdata | input | 8 | Key byte |
| din_wr | input | 1 | Data input port write strobe (only affects ready here) |
| key_valid_set | input | 1 | Software pulse that marks the key valid in mode 2'b11 |
| dout_rd | input | 1 | Output port read strobe, advances the byte pointer |
| dout_rdata | output | 8 | Output byte at the current read pointer |
| busy | output | 1 | Key generation in progress |
| ready | output | 1 | Result available |
| key_written | output | 1 | A complete key is held |
| out_read_done | output | 1 | All 16 result bytes have been read |

## Verification
The hardest case to reach from the ports is a run of key writes that lands while the schedule is running. The bench starts a generation and, inside the 53-cycle window, sends sixteen more key bytes with different values. It then checks that the result still matches the first key's schedule. A second awkward case is a half-loaded key cut off by a mode write. The bench writes five junk bytes, rewrites the mode, and then loads a full key whose expected last round key is known. A stale byte counter would therefore show up as a wrong result.

// File: rtl/aes_dkp_pkg.sv
`timescale 1ns/1ps
// Package aes_dkp_pkg
// Shared GF(2^8) arithmetic for the key pre-generator. The S-box is
// computed (multiplicative inverse followed by the affine map) rather
// than stored, so no 256-entry table appears in the source.
package aes_dkp_pkg;

    localparam int unsigned KEY_BYTES = 16;
    localparam logic [1:0]  MODE_GEN  = 2'b10;
    localparam logic [1:0]  MODE_DEC  = 2'b11;

    // Multiply by x modulo the AES polynomial.
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 (maps 0 to 0 as AES requires).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] e;
        r = 8'h01;
        e = 8'hfe;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (e[i]) r = gf_mul(r, a);
        end
        return r;
    endfunction

    // Forward S-box value.
    function automatic logic [7:0] sbox_f(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_dkp_sbox.sv
`timescale 1ns/1ps
// Module aes_dkp_sbox
// One combinational forward S-box lane.
// Assumes: purely combinational use; latency is absorbed by the caller.
module aes_dkp_sbox
    import aes_dkp_pkg::*;
(
    input  logic [7:0] a_i,
    output logic [7:0] s_o
);

    // Substitute one byte.
    always_comb s_o = sbox_f(a_i);

endmodule

// File: rtl/aes_dkp_round.sv
`timescale 1ns/1ps
// Module aes_dkp_round
// Computes the next AES-128 round key from the current one in a single
// combinational step: rotate and substitute the last word, add the round
// constant, then chain XORs across the four words.
// Assumes: word 0 occupies bits [127:96], byte 0 bits [127:120].
module aes_dkp_round #(
    parameter int unsigned KEY_W  = 128,
    parameter int unsigned WORD_W = 32
) (
    input  logic [KEY_W-1:0]  rk_i,
    input  logic [7:0]        rcon_i,
    output logic [KEY_W-1:0]  rk_o
);

    localparam int unsigned NWORDS = KEY_W / WORD_W;
    localparam int unsigned NLANES = WORD_W / 8;

    logic [WORD_W-1:0] last_w;
    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] sub_w;
    logic [WORD_W-1:0] w_in  [NWORDS];
    logic [WORD_W-1:0] w_out [NWORDS];

    // Split the incoming key into words.
    always_comb begin
        for (int i = 0; i < NWORDS; i++) w_in[i] = rk_i[KEY_W-1-WORD_W*i -: WORD_W];
    end

    // Rotate the last word left by one byte.
    always_comb begin
        last_w = w_in[NWORDS-1];
        rot_w  = {last_w[WORD_W-9:0], last_w[WORD_W-1 -: 8]};
    end

    genvar g;
    generate
        for (g = 0; g < NLANES; g++) begin : g_lane
            aes_dkp_sbox u_sbox (
                .a_i (rot_w[8*g +: 8]),
                .s_o (sub_w[8*g +: 8])
            );
        end
    endgenerate

    // Chain the word XORs to form the next round key.
    always_comb begin
        w_out[0] = w_in[0] ^ sub_w ^ {rcon_i, {(WORD_W-8){1'b0}}};
        for (int i = 1; i < NWORDS; i++) w_out[i] = w_in[i] ^ w_out[i-1];
        for (int i = 0; i < NWORDS; i++) rk_o[KEY_W-1-WORD_W*i -: WORD_W] = w_out[i];
    end

endmodule

// File: rtl/aes_dkp_seq.sv
`timescale 1ns/1ps
// Module aes_dkp_seq
// Generation sequencer. After start it holds busy for LATENCY cycles,
// enables one round per cycle during the first ROUNDS of them, steps the
// round constant, and pulses done in the last busy cycle.
// Assumes: start is only raised while busy is low; ROUNDS <= LATENCY.
module aes_dkp_seq
    import aes_dkp_pkg::*;
#(
    parameter int unsigned LATENCY = 53,
    parameter int unsigned ROUNDS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       busy_o,
    output logic       round_en_o,
    output logic       done_o,
    output logic [7:0] rcon_o
);

    localparam int unsigned CW = $clog2(LATENCY);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [7:0]    rcon_q;

    // Decode the cycle count into round enable and completion.
    always_comb begin
        round_en_o = busy_q && (cnt_q < CW'(ROUNDS));
        done_o     = busy_q && (cnt_q == CW'(LATENCY-1));
        busy_o     = busy_q;
        rcon_o     = rcon_q;
    end

    // Count busy cycles and advance the round constant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rcon_q <= 8'h01;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rcon_q <= 8'h01;
        end else if (busy_q) begin
            if (done_o) busy_q <= 1'b0;
            else        cnt_q  <= cnt_q + 1'b1;
            if (round_en_o) rcon_q <= xtime(rcon_q);
        end
    end

endmodule

// File: rtl/aes_dkey_pregen.sv
`timescale 1ns/1ps
// Module aes_dkey_pregen
// Byte-wide register front end for AES-128 decryption key generation.
// Holds the mode field, the 128-bit key/round-key buffer, the key and
// read byte pointers and the status flags; the sequencer and round
// logic expand the buffer in place to the tenth round key.
// Assumes: one strobe event per cycle per port; mode writes take
// precedence over a same-cycle key write.
module aes_dkey_pregen
    import aes_dkp_pkg::*;
#(
    parameter int unsigned LATENCY = 53,
    parameter int unsigned ROUNDS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    output logic [1:0] mode,
    input  logic       key_wr,
    input  logic [7:0] key_wdata,
    input  logic       din_wr,
    input  logic       key_valid_set,
    input  logic       dout_rd,
    output logic [7:0] dout_rdata,
    output logic       busy,
    output logic       ready,
    output logic       key_written,
    output logic       out_read_done
);

    localparam int unsigned KEY_W = 8 * KEY_BYTES;
    localparam int unsigned IDX_W = $clog2(KEY_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES-1);

    logic [1:0]       mode_q;
    logic [IDX_W-1:0] kcnt_q;
    logic [IDX_W-1:0] rcnt_q;
    logic [KEY_W-1:0] rk_q;
    logic [KEY_W-1:0] rk_next;
    logic             kw_q;
    logic             ready_q;
    logic             rdone_q;
    logic             key_take;
    logic             key_last;
    logic             start;
    logic             rd_take;
    logic             round_en;
    logic             done;
    logic [7:0]       rcon;

    // Qualify incoming strobes.
    always_comb begin
        key_take = key_wr && !busy && !mode_wr;
        key_last = key_take && (kcnt_q == LAST_IDX);
        start    = key_last && (mode_q == MODE_GEN);
        rd_take  = dout_rd && !busy;
    end

    aes_dkp_seq #(.LATENCY(LATENCY), .ROUNDS(ROUNDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .busy_o     (busy),
        .round_en_o (round_en),
        .done_o     (done),
        .rcon_o     (rcon)
    );

    aes_dkp_round #(.KEY_W(KEY_W), .WORD_W(32)) u_round (
        .rk_i   (rk_q),
        .rcon_i (rcon),
        .rk_o   (rk_next)
    );

    // Key buffer: byte loads from the port, in-place expansion when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rk_q <= '0;
        end else if (key_take) begin
            for (int b = 0; b < KEY_BYTES; b++)
                if (kcnt_q == IDX_W'(b)) rk_q[KEY_W-1-8*b -: 8] <= key_wdata;
        end else if (round_en) begin
            rk_q <= rk_next;
        end
    end

    // Mode field and key byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            kcnt_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_wdata;
            kcnt_q <= '0;
        end else if (key_take) begin
            kcnt_q <= kcnt_q + 1'b1;
        end
    end

    // Key-written flag: cleared by mode writes, set by a full load or by software in decrypt mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      kw_q <= 1'b0;
        else if (mode_wr)                                kw_q <= 1'b0;
        else if (key_last)                               kw_q <= 1'b1;
        else if (key_valid_set && (mode_q == MODE_DEC))  kw_q <= 1'b1;
    end

    // Ready flag: set on completion, cleared by port traffic.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ready_q <= 1'b0;
        else if (done)                        ready_q <= 1'b1;
        else if (dout_rd || key_wr || din_wr) ready_q <= 1'b0;
    end

    // Output read pointer and read-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q  <= '0;
            rdone_q <= 1'b0;
        end else if (start) begin
            rcnt_q  <= '0;
            rdone_q <= 1'b0;
        end else if (rd_take) begin
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q == LAST_IDX) rdone_q <= 1'b1;
        end
    end

    // Present the addressed result byte.
    always_comb begin
        dout_rdata = 8'h00;
        for (int b = 0; b < KEY_BYTES; b++)
            if (rcnt_q == IDX_W'(b)) dout_rdata = rk_q[KEY_W-1-8*b -: 8];
    end

    // Drive status outputs.
    always_comb begin
        mode          = mode_q;
        ready         = ready_q;
        key_written   = kw_q;
        out_read_done = rdone_q;
    end

endmodule

// File: rtl/aes_dkey_pregen_chk.sv
`timescale 1ns/1ps
// Module aes_dkey_pregen_chk
// Property checker bound to aes_dkey_pregen. Observes ports only and
// measures busy length with its own counter.
// Assumes: synchronous active-low reset shared with the design.
module aes_dkey_pregen_chk #(
    parameter int unsigned LATENCY = 53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic       key_wr,
    input logic       din_wr,
    input logic       key_valid_set,
    input logic       dout_rd,
    input logic       busy,
    input logic       ready,
    input logic       key_written,
    input logic       out_read_done
);

    localparam int unsigned BW = $clog2(LATENCY + 2);

    logic [BW-1:0] blen_q;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    blen_q <= '0;
        else if (busy) blen_q <= blen_q + 1'b1;
        else           blen_q <= '0;
    end

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == BW'(LATENCY)));

    assert_ready_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ready);

    assert_mode_clears_kw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !key_written);

    assert_kw_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_written) |-> $past(key_wr || key_valid_set));

    assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (dout_rd || key_wr || din_wr)) |=> !ready);

    assert_read_done_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_read_done) |-> $past(dout_rd));

    assert_busy_hides_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);

endmodule

bind aes_dkey_pregen aes_dkey_pregen_chk #(.LATENCY(LATENCY)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_wr       (mode_wr),
    .key_wr        (key_wr),
    .din_wr        (din_wr),
    .key_valid_set (key_valid_set),
    .dout_rd       (dout_rd),
    .busy          (busy),
    .ready         (ready),
    .key_written   (key_written),
    .out_read_done (out_read_done)
);

// File: tb/aes_dkey_pregen_tb_top.sv
`timescale 1ns/1ps
// Directed bench for aes_dkey_pregen: one task per scenario, each
// checking its own results against known AES-128 schedule vectors.
module aes_dkey_pregen_tb_top;

    localparam realtime CLK_P = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic [1:0] mode;
    logic       key_wr = 1'b0;
    logic [7:0] key_wdata = 8'h00;
    logic       din_wr = 1'b0;
    logic       key_valid_set = 1'b0;
    logic       dout_rd = 1'b0;
    logic [7:0] dout_rdata;
    logic       busy, ready, key_written, out_read_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] RK_A  = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
    localparam logic [127:0] KEY_B = 128'h0;
    localparam logic [127:0] RK_B  = 128'hb4ef5bcb3e92e21123e951cf6f8f188e;
    localparam logic [127:0] KEY_C = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] RK_C  = 128'h13111d7fe3944a17f307a78b4d2b30c5;

    always #(CLK_P/2) clk = ~clk;

    aes_dkey_pregen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_wr       (mode_wr),
        .mode_wdata    (mode_wdata),
        .mode          (mode),
        .key_wr        (key_wr),
        .key_wdata     (key_wdata),
        .din_wr        (din_wr),
        .key_valid_set (key_valid_set),
        .dout_rd       (dout_rd),
        .dout_rdata    (dout_rdata),
        .busy          (busy),
        .ready         (ready),
        .key_written   (key_written),
        .out_read_done (out_read_done)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [1:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
        @(posedge clk); #1; mode_wr = 1'b0;
    endtask

    task automatic wr_key_byte(input logic [7:0] b);
        @(negedge clk); key_wr = 1'b1; key_wdata = b;
        @(posedge clk); #1; key_wr = 1'b0;
    endtask

    task automatic pulse_din();
        @(negedge clk); din_wr = 1'b1;
        @(posedge clk); #1; din_wr = 1'b0;
    endtask

    task automatic pulse_valid();
        @(negedge clk); key_valid_set = 1'b1;
        @(posedge clk); #1; key_valid_set = 1'b0;
    endtask

    // Load 16 bytes, byte 0 first; check key_written around the last byte (R3).
    task automatic load_key(input logic [127:0] k);
        for (int i = 0; i < 16; i++) begin
            wr_key_byte(k[127-8*i -: 8]);
            if (i == 14) chk("R3 kw before 16th byte", key_written, 0);
        end
        chk("R3 kw after 16th byte", key_written, 1);
    endtask

    // Wait for busy to drop; return the number of busy cycles observed.
    task automatic wait_done(output int n);
        n = 0;
        while (busy && n < 200) begin
            @(posedge clk); #1; n++;
        end
    endtask

    // Read and compare all 16 output bytes (R5, R6, R7).
    task automatic read_check(input string req, input logic [127:0] exp);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(req, dout_rdata, exp[127-8*i -: 8]);
            dout_rd = 1'b1;
            @(posedge clk); #1; dout_rd = 1'b0;
            if (i == 0)  chk("R7 ready cleared by read", ready, 0);
            if (i == 14) chk("R6 read-done before 16th read", out_read_done, 0);
            if (i == 15) chk("R6 read-done after 16th read", out_read_done, 1);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 ready", ready, 0);
        chk("R1 key_written", key_written, 0);
        chk("R1 out_read_done", out_read_done, 0);
        chk("R1 mode", mode, 2'b00);
    endtask

    task automatic t_gen_basic();
        int n;
        wr_mode(2'b10);
        chk("R2 mode readback", mode, 2'b10);
        load_key(KEY_A);
        chk("R4 busy after load", busy, 1);
        chk("R6 read-done cleared at start", out_read_done, 0);
        wait_done(n);
        chk("R4 busy length", n, 53);
        chk("R5 ready at finish", ready, 1);
        read_check("R5 round-10 key A", RK_A);
    endtask

    task automatic t_busy_ignore();
        int n;
        wr_mode(2'b10);
        load_key(KEY_B);
        for (int i = 0; i < 16; i++) wr_key_byte(8'hff - 8'(i));
        chk("R9 still busy", busy, 1);
        wait_done(n);
        chk("R9 kw kept", key_written, 1);
        chk("R5 ready", ready, 1);
        read_check("R9 result unaffected", RK_B);
    endtask

    task automatic t_restart();
        int n;
        wr_mode(2'b10);
        for (int i = 0; i < 5; i++) wr_key_byte(8'ha5);
        wr_mode(2'b10);
        chk("R2 kw cleared by mode write", key_written, 0);
        load_key(KEY_C);
        wait_done(n);
        chk("R4 busy length C", n, 53);
        read_check("R2 counter restarted, key C", RK_C);
    endtask

    task automatic t_ready_clear();
        int n;
        wr_mode(2'b10);
        load_key(KEY_A);
        wait_done(n);
        chk("R5 ready", ready, 1);
        pulse_din();
        chk("R7 ready cleared by din write", ready, 0);
        wr_mode(2'b10);
        load_key(KEY_A);
        wait_done(n);
        chk("R5 ready again", ready, 1);
        wr_key_byte(8'h00);
        chk("R7 ready cleared by key write", ready, 0);
        chk("R10 single byte starts nothing", busy, 0);
    endtask

    task automatic t_mode_dec();
        wr_mode(2'b11);
        chk("R2 kw clear on mode 11", key_written, 0);
        pulse_valid();
        chk("R8 valid set in mode 11", key_written, 1);
        wr_mode(2'b10);
        pulse_valid();
        chk("R8 valid ignored in mode 10", key_written, 0);
        wr_mode(2'b11);
        load_key(KEY_C);
        chk("R10 no generation in mode 11", busy, 0);
        repeat (3) @(posedge clk);
        #1;
        chk("R10 still idle", busy, 0);
        chk("R10 no ready", ready, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_gen_basic();
        t_busy_ignore();
        t_restart();
        t_ready_clear();
        t_mode_dec();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule